// File: doc/BRIEF.md
# Per-Bank Request Dispatcher

This block sits in front of a memory command scheduler. It takes memory requests that each name a bank, a row and a direction (read or write). It keeps a separate first-in-first-out queue for every bank. It then hands the oldest request of one bank at a time to the scheduler. A request is offered only while its bank is not busy, and it leaves its queue only when the scheduler accepts it. A rejected request stays at the head of its queue.

For every bank the block records three things. The first is the kind of the last command (none, an access, or a refresh). The second is a countdown to the start of the last access. The third is the row that is currently open. The scheduler returns the cycle distance to the start of the accepted access. A refresh is framed by a start pulse and an end pulse. The end pulse releases every bank and clears every rejection.

The dispatcher is a two-state machine. In `DS_IDLE` it runs SELECT: if any bank is eligible, it latches the lowest such bank and moves to `DS_OFFER`. In `DS_OFFER` it drives the head of that bank on the output. There are three transitions out of `DS_OFFER`:
- TAKE returns to `DS_IDLE` on an accept and pops the head.
- REFUSE returns to `DS_IDLE` on a reject and blocks the bank.
- HOLD stays in `DS_OFFER` while the scheduler has not answered.

Top module: `bank_dispatch`

## Requirements
- R1: Requests to the same bank are offered in the order of their handshakes. While `out_valid` is high, `out_bank`, `out_row` and `out_write` show the head of the selected bank's queue.
- R2: A request leaves its queue only on an accept. A rejected request is offered again later with unchanged fields. An offer stays on the outputs, with the same bank, until the scheduler answers.
- R3: A reject blocks that bank from further offers until a `ref_done` pulse. Other banks continue to be served.
- R4: A bank that has had no command since reset is never busy. A request that completes its handshake in cycle h, on an empty and idle dispatcher, is offered in cycle h+3: one cycle in staging, one cycle in the queue, one cycle of selection.
- R5: Suppose an offer of bank b is accepted in cycle c with `sch_delay` = D. Then bank b counts as busy until the start of its access, and its next queued request is offered in cycle c+D+2.
- R6: A `ref_start` pulse marks every bank as last-commanded by a refresh. Every bank stays busy until the `ref_done` pulse, and all open rows are closed. After `ref_done`, all banks are eligible again.
- R7: After reset, `open_valid` is all zero. An accept for bank b sets `open_valid[b]` and places the request's row in `open_rows[b*ROW_W +: ROW_W]`. A refresh start clears every `open_valid` bit. `ref_start` takes priority over an accept in the same cycle.
- R8: When several banks are eligible in the same cycle, they are offered in ascending bank index, one offer at a time.
- R9: `in_ready` is low exactly when the occupancy of the addressed bank equals `QUEUE_DEPTH`. Occupancy counts the queued entries plus a staged entry for that bank. No handshaked request is lost or duplicated.
- R10: `proto_err` rises when a queue is peeked or popped while empty. Under legal operation it stays low.
- R11: `sch_accept` and `sch_reject` are ignored while `out_valid` is low. When both are high during an offer, the accept wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming request valid |
| in_ready | output | 1 | Addressed bank can take a request |
| in_bank | input | BANK_W | Bank index of incoming request |
| in_row | input | ROW_W | Row of incoming request |
| in_write | input | 1 | 1 = write, 0 = read |
| out_valid | output | 1 | Request offered to scheduler |
| out_bank | output | BANK_W | Bank of offered request |
| out_row | output | ROW_W | Row of offered request |
| out_write | output | 1 | Direction of offered request |
| sch_accept | input | 1 | Scheduler takes the offer |
| sch_reject | input | 1 | Scheduler refuses the offer (refresh collision) |
| sch_delay | input | DLY_W | Cycles from accept to start of the access |
| ref_start | input | 1 | Refresh begins on all banks |
| ref_done | input | 1 | Refresh has ended |
| open_valid | output | NUM_BANKS | Per-bank open-row flag |
| open_rows | output | NUM_BANKS*ROW_W | Per-bank open row, bank b at bits b*ROW_W upward |
| proto_err | output | 1 | Empty-queue peek or pop |

## Verification
The refresh end and the arrival path can act in the same cycle. When several banks are released at once, their queued requests contend for the single offer slot. The bench fills all four queues during a refresh and then pulses `ref_done`. It then judges that the offers come out in ascending bank order, with no offer made while the refresh was running. A reference model of queues and counters, updated on every clock, also covers the case where a bank's release coincides with a fresh enqueue on another bank. It compares the offer, `in_ready` and the open rows every cycle.

// File: rtl/bank_dispatch_pkg.sv
package bank_dispatch_pkg;

    // kind of the last command seen by a bank
    typedef enum logic [1:0] {
        LK_NONE    = 2'd0,
        LK_ACCESS  = 2'd1,
        LK_REFRESH = 2'd2
    } last_kind_t;

    // dispatcher states
    typedef enum logic {
        DS_IDLE  = 1'b0,
        DS_OFFER = 1'b1
    } disp_state_t;

endpackage

// File: rtl/bank_queue.sv
module bank_queue #(
    parameter int DEPTH = 4,
    parameter int ROW_W = 14,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ROW_W-1:0] push_row,
    input  logic             push_wr,
    input  logic             pop,
    input  logic             peek,
    output logic [CNT_W-1:0] count,
    output logic [ROW_W-1:0] head_row,
    output logic             head_wr,
    output logic             misuse
);

    logic [ROW_W:0]   slot [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic             do_pop;
    logic             do_push;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign do_pop  = pop && (count != '0);
    assign do_push = push && (count != CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (do_push) slot[wr_ptr] <= {push_wr, push_row};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign {head_wr, head_row} = slot[rd_ptr];
    assign misuse = (pop || peek) && (count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CNT_W'(DEPTH))); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0)); // R10

endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
    import bank_dispatch_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_start,
    input  logic             ref_done,
    input  logic             ref_running,
    input  logic             accept,
    input  logic [ROW_W-1:0] accept_row,
    input  logic [DLY_W-1:0] accept_dly,
    input  logic             reject,
    input  logic             has_work,
    output logic             eligible,
    output logic             open_v,
    output logic [ROW_W-1:0] open_row
);

    last_kind_t       kind;
    logic [DLY_W-1:0] left;
    logic             blocked;
    logic             busy;

    // last command, countdown to its start, open row
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind     <= LK_NONE;
            left     <= '0;
            open_v   <= 1'b0;
            open_row <= '0;
        end else if (ref_start) begin
            kind   <= LK_REFRESH;
            left   <= '0;
            open_v <= 1'b0;
        end else if (accept) begin
            kind     <= LK_ACCESS;
            left     <= accept_dly;
            open_v   <= 1'b1;
            open_row <= accept_row;
        end else if (left != '0) begin
            left <= left - DLY_W'(1);
        end
    end

    // a refused bank waits for the end of the refresh
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        blocked <= 1'b0;
        else if (ref_done) blocked <= 1'b0;
        else if (reject)   blocked <= 1'b1;
    end

    always_comb begin
        unique case (kind)
            LK_NONE:    busy = 1'b0;
            LK_ACCESS:  busy = (left != '0);
            LK_REFRESH: busy = ref_running;
            default:    busy = 1'b0;
        endcase
        eligible = has_work && !busy && !blocked;
    end

    AST_REFRESH_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        ref_start |=> !open_v); // R6
    AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ref_start) |=> (open_v && open_row == $past(accept_row))); // R7
    AST_ACCESS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ref_start && accept_dly != '0) |=> !eligible); // R5
    AST_REJECT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (reject && !ref_done) |=> !eligible); // R3

endmodule

// File: rtl/dispatch_fsm.sv
module dispatch_fsm
    import bank_dispatch_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] eligible,
    input  logic                 sch_accept,
    input  logic                 sch_reject,
    output logic                 offer_valid,
    output logic [BANK_W-1:0]    sel_bank,
    output logic                 take,
    output logic                 refuse
);

    disp_state_t       state;
    disp_state_t       state_nx;
    logic [BANK_W-1:0] sel_nx;
    logic              pick_any;
    logic [BANK_W-1:0] pick;

    // lowest eligible bank wins
    always_comb begin
        pick_any = 1'b0;
        pick     = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                pick_any = 1'b1;
                pick     = BANK_W'(i);
            end
        end
    end

    always_comb begin
        state_nx = state;
        sel_nx   = sel_bank;
        unique case (state)
            DS_IDLE: begin
                if (pick_any) begin
                    state_nx = DS_OFFER;
                    sel_nx   = pick;
                end
            end
            DS_OFFER: begin
                if (sch_accept || sch_reject) state_nx = DS_IDLE;
            end
            default: state_nx = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= DS_IDLE;
            sel_bank <= '0;
        end else begin
            state    <= state_nx;
            sel_bank <= sel_nx;
        end
    end

    always_comb begin
        offer_valid = (state == DS_OFFER);
        take        = offer_valid && sch_accept;
        refuse      = offer_valid && !sch_accept && sch_reject;
    end

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && !sch_accept && !sch_reject) |=> (offer_valid && $stable(sel_bank))); // R2
    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(offer_valid) |-> (($past(eligible) & ((NUM_BANKS'(1) << sel_bank) - NUM_BANKS'(1))) == '0)); // R8

endmodule

// File: rtl/bank_dispatch.sv
module bank_dispatch
    import bank_dispatch_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int QUEUE_DEPTH = 4,
    parameter int ROW_W       = 14,
    parameter int DLY_W       = 6,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [BANK_W-1:0]          in_bank,
    input  logic [ROW_W-1:0]           in_row,
    input  logic                       in_write,
    output logic                       out_valid,
    output logic [BANK_W-1:0]          out_bank,
    output logic [ROW_W-1:0]           out_row,
    output logic                       out_write,
    input  logic                       sch_accept,
    input  logic                       sch_reject,
    input  logic [DLY_W-1:0]           sch_delay,
    input  logic                       ref_start,
    input  logic                       ref_done,
    output logic [NUM_BANKS-1:0]       open_valid,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows,
    output logic                       proto_err
);

    localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

    logic              stage_v;
    logic [BANK_W-1:0] stage_bank;
    logic [ROW_W-1:0]  stage_row;
    logic              stage_wr;
    logic              ref_running;

    logic [CNT_W-1:0]     q_cnt [NUM_BANKS];
    logic [ROW_W-1:0]     q_row [NUM_BANKS];
    logic [NUM_BANKS-1:0] q_wr;
    logic [NUM_BANKS-1:0] elig;
    logic [NUM_BANKS-1:0] misuse;

    logic [BANK_W-1:0] sel_bank;
    logic              offer;
    logic              take;
    logic              refuse;
    logic [CNT_W:0]    occ;

    // room check counts the entry still in staging
    always_comb begin
        occ = {1'b0, q_cnt[in_bank]};
        if (stage_v && stage_bank == in_bank) occ = occ + (CNT_W + 1)'(1);
        in_ready = occ < (CNT_W + 1)'(QUEUE_DEPTH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_v    <= 1'b0;
            stage_bank <= '0;
            stage_row  <= '0;
            stage_wr   <= 1'b0;
        end else begin
            stage_v <= in_valid && in_ready;
            if (in_valid && in_ready) begin
                stage_bank <= in_bank;
                stage_row  <= in_row;
                stage_wr   <= in_write;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ref_running <= 1'b0;
        else if (ref_start) ref_running <= 1'b1;
        else if (ref_done)  ref_running <= 1'b0;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic is_sel;
        logic push_here;
        logic has_work;

        assign is_sel    = (sel_bank == BANK_W'(b));
        assign push_here = stage_v && (stage_bank == BANK_W'(b));
        assign has_work  = (q_cnt[b] != '0);

        bank_queue #(
            .DEPTH (QUEUE_DEPTH),
            .ROW_W (ROW_W)
        ) u_queue (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push_here),
            .push_row (stage_row),
            .push_wr  (stage_wr),
            .pop      (take && is_sel),
            .peek     (offer && is_sel),
            .count    (q_cnt[b]),
            .head_row (q_row[b]),
            .head_wr  (q_wr[b]),
            .misuse   (misuse[b])
        );

        bank_tracker #(
            .ROW_W (ROW_W),
            .DLY_W (DLY_W)
        ) u_track (
            .clk         (clk),
            .rst_n       (rst_n),
            .ref_start   (ref_start),
            .ref_done    (ref_done),
            .ref_running (ref_running),
            .accept      (take && is_sel),
            .accept_row  (q_row[b]),
            .accept_dly  (sch_delay),
            .reject      (refuse && is_sel),
            .has_work    (has_work),
            .eligible    (elig[b]),
            .open_v      (open_valid[b]),
            .open_row    (open_rows[b*ROW_W +: ROW_W])
        );
    end

    dispatch_fsm #(
        .NUM_BANKS (NUM_BANKS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .eligible    (elig),
        .sch_accept  (sch_accept),
        .sch_reject  (sch_reject),
        .offer_valid (offer),
        .sel_bank    (sel_bank),
        .take        (take),
        .refuse      (refuse)
    );

    assign out_valid = offer;
    assign out_bank  = sel_bank;
    assign out_row   = q_row[sel_bank];
    assign out_write = q_wr[sel_bank];
    assign proto_err = |misuse;

    AST_STAGE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> stage_v); // R9
    AST_REFRESH_NO_NEW_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_running && !ref_done && !offer) |=> !offer); // R6

endmodule

// File: tb/bank_dispatch_test.sv
module bank_dispatch_test;

    localparam int NB = 4;
    localparam int DEPTH = 4;
    localparam int ROW_W = 14;
    localparam int DLY_W = 6;
    localparam int BW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_write = 1'b0;
    logic [BW-1:0] in_bank = '0;
    logic [ROW_W-1:0] in_row = '0;
    logic in_ready, out_valid, out_write, proto_err;
    logic [BW-1:0] out_bank;
    logic [ROW_W-1:0] out_row;
    logic sch_accept = 1'b0, sch_reject = 1'b0;
    logic [DLY_W-1:0] sch_delay = '0;
    logic ref_start = 1'b0, ref_done = 1'b0;
    logic [NB-1:0] open_valid;
    logic [NB*ROW_W-1:0] open_rows;

    always #5 clk = ~clk;

    bank_dispatch #(.NUM_BANKS(NB), .QUEUE_DEPTH(DEPTH), .ROW_W(ROW_W), .DLY_W(DLY_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bank(in_bank),
        .in_row(in_row), .in_write(in_write), .out_valid(out_valid), .out_bank(out_bank),
        .out_row(out_row), .out_write(out_write), .sch_accept(sch_accept), .sch_reject(sch_reject),
        .sch_delay(sch_delay), .ref_start(ref_start), .ref_done(ref_done),
        .open_valid(open_valid), .open_rows(open_rows), .proto_err(proto_err));

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // request source
    int src_b[16], src_r[16], src_n = 0;
    bit src_w[16];
    // scheduler policy and pulses
    bit pol_rej = 0, stray = 0, want_rs = 0, want_rd = 0;
    int pol_dly = 4;
    // offer log
    int lg_b[64], lg_r[64], lg_c[64], lgn = 0;

    // reference model
    int m_qn[NB], m_qr[NB][DEPTH], m_kind[NB], m_left[NB], m_orow[NB];
    bit m_qw[NB][DEPTH], m_ov[NB], m_blk[NB];
    bit m_stv, m_stw, m_refrun, m_offer;
    int m_stb, m_str, m_sel;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic bit m_busy(input int b);
        return (m_kind[b] == 1 && m_left[b] != 0) || (m_kind[b] == 2 && m_refrun);
    endfunction
    function automatic bit m_elig(input int b);
        return m_qn[b] != 0 && !m_busy(b) && !m_blk[b];
    endfunction
    function automatic bit m_ready(input int b);
        int occ = m_qn[b] + ((m_stv && m_stb == b) ? 1 : 0);
        return occ < DEPTH;
    endfunction

    task automatic m_reset();
        for (int b = 0; b < NB; b++) begin
            m_qn[b] = 0; m_kind[b] = 0; m_left[b] = 0; m_ov[b] = 0; m_orow[b] = 0; m_blk[b] = 0;
        end
        m_stv = 0; m_refrun = 0; m_offer = 0; m_sel = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            bit acc, rej, hs, el[NB], nof;
            int nsel, hrow;
            acc = m_offer && sch_accept;
            rej = m_offer && !sch_accept && sch_reject;
            hs = in_valid && m_ready(int'(in_bank));
            for (int b = 0; b < NB; b++) el[b] = m_elig(b);
            nof = m_offer; nsel = m_sel;
            if (!m_offer) begin
                for (int b = NB - 1; b >= 0; b--) if (el[b]) begin nof = 1; nsel = b; end
            end else if (acc || rej) nof = 0;
            hrow = m_qr[m_sel][0];
            if (acc) begin
                for (int k = 0; k < DEPTH - 1; k++) begin
                    m_qr[m_sel][k] = m_qr[m_sel][k+1]; m_qw[m_sel][k] = m_qw[m_sel][k+1];
                end
                m_qn[m_sel]--;
            end
            if (m_stv) begin
                m_qr[m_stb][m_qn[m_stb]] = m_str; m_qw[m_stb][m_qn[m_stb]] = m_stw; m_qn[m_stb]++;
            end
            m_stv = hs;
            if (hs) begin m_stb = int'(in_bank); m_str = int'(in_row); m_stw = in_write; end
            for (int b = 0; b < NB; b++) begin
                if (ref_start) begin m_kind[b] = 2; m_left[b] = 0; m_ov[b] = 0; end
                else if (acc && b == m_sel) begin
                    m_kind[b] = 1; m_left[b] = int'(sch_delay); m_ov[b] = 1; m_orow[b] = hrow;
                end else if (m_left[b] != 0) m_left[b]--;
                if (ref_done) m_blk[b] = 0;
                else if (rej && b == m_sel) m_blk[b] = 1;
            end
            if (ref_start) m_refrun = 1; else if (ref_done) m_refrun = 0;
            m_offer = nof; m_sel = nsel;
            if (hs) begin
                for (int k = 0; k < 15; k++) begin
                    src_b[k] = src_b[k+1]; src_r[k] = src_r[k+1]; src_w[k] = src_w[k+1];
                end
                src_n--;
            end
        end
    end

    task automatic compare();
        chk(out_valid == m_offer, "R1", "out_valid", out_valid, m_offer);
        if (m_offer && out_valid) begin
            chk(int'(out_bank) == m_sel, "R8", "out_bank", out_bank, m_sel);
            chk(int'(out_row) == m_qr[m_sel][0], "R1", "out_row", out_row, m_qr[m_sel][0]);
            chk(out_write == m_qw[m_sel][0], "R1", "out_write", out_write, m_qw[m_sel][0]);
            if (lgn < 64) begin lg_b[lgn] = out_bank; lg_r[lgn] = out_row; lg_c[lgn] = cyc; lgn++; end
        end
        chk(in_ready == m_ready(int'(in_bank)), "R9", "in_ready", in_ready, m_ready(int'(in_bank)));
        for (int b = 0; b < NB; b++) begin
            chk(open_valid[b] == m_ov[b], "R7", "open_valid", open_valid[b], m_ov[b]);
            if (m_ov[b])
                chk(int'(open_rows[b*ROW_W +: ROW_W]) == m_orow[b], "R7", "open_row",
                    open_rows[b*ROW_W +: ROW_W], m_orow[b]);
        end
        chk(proto_err == 1'b0, "R10", "proto_err", proto_err, 0);
    endtask

    task automatic send(input int b, input int r, input bit w);
        src_b[src_n] = b; src_r[src_n] = r; src_w[src_n] = w; src_n++;
    endtask

    task automatic run(input int n);
        repeat (n) begin
            @(negedge clk);
            cyc++;
            in_valid = (src_n > 0);
            in_bank = (src_n > 0) ? BW'(src_b[0]) : '0;
            in_row = (src_n > 0) ? ROW_W'(src_r[0]) : '0;
            in_write = (src_n > 0) ? src_w[0] : 1'b0;
            ref_start = want_rs; want_rs = 0;
            ref_done = want_rd; want_rd = 0;
            #1;
            compare();
            sch_accept = out_valid && !pol_rej;
            sch_reject = out_valid && pol_rej;
            sch_delay = DLY_W'(pol_dly);
            if (stray && !out_valid) begin sch_accept = 1; sch_reject = 1; stray = 0; end
        end
    endtask

    initial begin
        int h, base;
        m_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 0, "R4", "reset out_valid", out_valid, 0);
        chk(open_valid == '0, "R7", "reset open_valid", open_valid, 0);
        chk(in_ready == 1, "R9", "reset in_ready", in_ready, 1);
        chk(proto_err == 0, "R10", "reset proto_err", proto_err, 0);

        // same bank, three requests, delay 4
        pol_dly = 4; h = cyc + 1;
        send(0, 5, 0); send(0, 6, 1); send(0, 7, 0);
        run(30);
        chk(lgn == 3, "R1", "offers bank0", lgn, 3);
        chk(lg_c[0] == h + 3, "R4", "first offer cycle", lg_c[0], h + 3);
        chk(lg_c[1] - lg_c[0] == 6, "R5", "access spacing", lg_c[1] - lg_c[0], 6);
        chk(lg_r[0] == 5 && lg_r[1] == 6 && lg_r[2] == 7, "R1", "order", lg_r[2], 7);
        chk(int'(open_rows[0 +: ROW_W]) == 7, "R7", "bank0 open row", open_rows[0 +: ROW_W], 7);

        // refresh holds all banks, then release in ascending order
        want_rs = 1; run(2);
        chk(open_valid == '0, "R6", "rows closed", open_valid, 0);
        send(3, 30, 0); send(2, 20, 1); send(1, 10, 0); send(0, 40, 1);
        base = lgn; run(12);
        chk(lgn == base, "R6", "no offer in refresh", lgn - base, 0);
        want_rd = 1; run(20);
        chk(lgn == base + 4, "R8", "released offers", lgn - base, 4);
        for (int k = 0; k < 4; k++) chk(lg_b[base + k] == k, "R8", "ascending bank", lg_b[base + k], k);

        // reject blocks bank 1 only
        pol_rej = 1; base = lgn;
        send(1, 99, 1); run(6);
        pol_rej = 0; run(6);
        chk(lgn == base + 1 && lg_b[base] == 1, "R3", "single rejected offer", lgn - base, 1);
        send(2, 55, 0); run(10);
        chk(lgn == base + 2 && lg_b[base + 1] == 2, "R3", "other bank served", lg_b[base + 1], 2);
        want_rd = 1; run(10);
        chk(lgn == base + 3 && lg_b[base + 2] == 1, "R2", "bank1 re-offered", lg_b[base + 2], 1);
        chk(lg_r[base + 2] == 99, "R2", "same row", lg_r[base + 2], 99);

        // queue full back-pressure
        want_rs = 1; run(2);
        for (int k = 0; k < 6; k++) send(2, 60 + k, k[0]);
        run(10);
        chk(in_ready == 0, "R9", "ready low when full", in_ready, 0);
        chk(src_n == 2, "R9", "pending left", src_n, 2);
        base = lgn; want_rd = 1; run(60);
        chk(lgn == base + 6, "R9", "all delivered", lgn - base, 6);
        for (int k = 0; k < 6; k++) chk(lg_r[base + k] == 60 + k, "R1", "full-queue order", lg_r[base + k], 60 + k);

        // stray response while idle
        want_rs = 1; run(2);
        send(3, 77, 0); run(5);
        stray = 1; base = lgn; run(3);
        chk(open_valid[3] == 0, "R11", "stray accept ignored", open_valid[3], 0);
        chk(lgn == base, "R11", "no offer", lgn - base, 0);
        want_rd = 1; run(10);
        chk(lgn == base + 1 && lg_r[base] == 77, "R11", "request kept", lg_r[base], 77);
        chk(open_valid[3] == 1 && int'(open_rows[3*ROW_W +: ROW_W]) == 77, "R7", "bank3 opened",
            open_rows[3*ROW_W +: ROW_W], 77);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule